// File: doc/BRIEF.md
# Flattened-Butterfly Route Unit with Adaptive Dimension Order

This block is the route-computation stage for one router of a two-dimensional flattened butterfly. Every router serves a group of local terminals and has a direct link to each other router that shares its row or its column. For every head flit it takes the destination terminal, the router's own identifier, the input port the flit arrived on, its traffic class and its current virtual channel. It returns the output port and the range of virtual channels the flit may request there.

A flit can correct its row and column coordinates in either order. The order is chosen once, on the hop that accepts the flit from a local terminal. That hop compares the used-credit counts of the two candidate output ports and takes the less loaded one. A pseudo-random bit breaks ties. Each order owns one half of the class's virtual channels, so later hops read the order back from the channel the flit holds, and the two orders never share buffers.

The result is registered and appears, with a valid flag, one clock after the request.

Top module: `frf_route_unit`

## Requirements
- R1: When the destination router (destination index divided by C) equals the own router, the output is the destination index modulo C (ports 0 to C-1 are ejection ports) and the allowed VC range is the whole class range.
- R2: The port for correcting dimension d (digit 0 = router ID modulo K, digit 1 = router ID divided by K) is C+(K-1)*d-1+t when the target digit t exceeds the own digit, and C+(K-1)*d+t otherwise.
- R3: XY order corrects digit 0 first whenever it differs. YX order corrects digit 1 first whenever it differs.
- R4: On a request whose input port is below C, the order whose candidate port has the smaller used-credit count is chosen. Port p's count is used_credits[p*CW +: CW]. rsp_xy is 1 for XY.
- R5: On equal counts the order is taken from bit 0 of a 16-bit LFSR, where 1 means XY. The LFSR is seeded to 0xACE1 at reset. On every valid request it shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R6: On a request whose input port is C or above, the order is XY when the VC offset within its class (req_vc - class*VPC) is below VPC/2, and YX otherwise.
- R7: The class base is class*VPC. Outside ejection, XY flits may use base to base+VPC/2-1, and YX flits may use base+VPC/2 to base+VPC-1.
- R8: rsp_valid is set in the cycle after a cycle with req_valid high, and is low otherwise. Reset clears rsp_valid and rsp_err.
- R9: rsp_err is set when the input port is at or above the radix C+(K-1)*N, when the computed port is at or above the radix, or when a request on a port at or above C carries a VC outside its class. The VC is not checked on injection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head flit to route this cycle |
| req_dest | input | 6 | Destination terminal index |
| req_router | input | 4 | Own router identifier |
| req_in_port | input | 4 | Input port of the flit |
| req_class | input | 1 | Traffic class |
| req_vc | input | 3 | Current virtual channel |
| used_credits | input | 40 | Used-credit count per output port, CW bits each |
| rsp_valid | output | 1 | Result valid |
| rsp_port | output | 4 | Selected output port |
| rsp_vc_lo | output | 3 | Lowest allowed VC |
| rsp_vc_hi | output | 3 | Highest allowed VC |
| rsp_xy | output | 1 | Order in use, 1 = XY |
| rsp_err | output | 1 | Request could not be routed |

## Verification
The hardest case to reach is the tie on injection. The tie bit comes from an LFSR that advances on every request, so an expected value depends on how many requests came before. The bench keeps its own copy of the register sequence and counts every request, including erroneous ones. It then drives one credit pattern in which every port shows the same count, so every injection is a tie, and two graded patterns where ties happen only when both candidate ports coincide. Every pairing of router and destination is swept on both transit VC halves and on injection.

// File: rtl/frf_pkg.sv
package frf_pkg;
    parameter int FRF_K    = 4;   // routers per dimension
    parameter int FRF_N    = 2;   // dimensions
    parameter int FRF_C    = 4;   // terminals per router
    parameter int FRF_VPC  = 4;   // VCs per traffic class
    parameter int FRF_NCLS = 2;   // traffic classes
    parameter int FRF_CW   = 4;   // used-credit counter width
    parameter logic [15:0] FRF_LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/frf_port_calc.sv
module frf_port_calc #(
    parameter int K = 4,
    parameter int N = 2,
    parameter int C = 4,
    parameter int DW = 6,
    parameter int RW = 4,
    parameter int PW = 4,
    parameter bit YX_ORDER = 1'b0
) (
    input  logic [DW-1:0] dest,
    input  logic [RW-1:0] self_id,
    output logic [PW-1:0] port
);
    always_comb begin
        int drt, srt, dd, sd, dim, p;
        logic done;
        drt  = int'(dest) / C;
        srt  = int'(self_id);
        p    = int'(dest) % C;
        done = (drt == srt);
        for (int i = 0; i < N; i++) begin
            dim = YX_ORDER ? (N - 1 - i) : i;
            dd  = (drt / (K ** dim)) % K;
            sd  = (srt / (K ** dim)) % K;
            if (!done && dd != sd) begin
                p    = (dd > sd) ? (C + (K - 1) * dim - 1 + dd) : (C + (K - 1) * dim + dd);
                done = 1'b1;
            end
        end
        port = PW'(p);
    end
endmodule

// File: rtl/frf_lfsr.sv
module frf_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic rnd_bit
);
    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rnd_bit = state_q[0];
endmodule

// File: rtl/frf_route_unit.sv
module frf_route_unit
    import frf_pkg::*;
#(
    parameter int K    = FRF_K,
    parameter int N    = FRF_N,
    parameter int C    = FRF_C,
    parameter int VPC  = FRF_VPC,
    parameter int NCLS = FRF_NCLS,
    parameter int CW   = FRF_CW,
    localparam int NROUT = K ** N,
    localparam int RADIX = C + (K - 1) * N,
    localparam int DW    = $clog2(NROUT * C),
    localparam int RW    = $clog2(NROUT),
    localparam int PW    = $clog2(RADIX),
    localparam int VW    = $clog2(VPC * NCLS),
    localparam int CLW   = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DW-1:0]     req_dest,
    input  logic [RW-1:0]     req_router,
    input  logic [PW-1:0]     req_in_port,
    input  logic [CLW-1:0]    req_class,
    input  logic [VW-1:0]     req_vc,
    input  logic [RADIX*CW-1:0] used_credits,
    output logic              rsp_valid,
    output logic [PW-1:0]     rsp_port,
    output logic [VW-1:0]     rsp_vc_lo,
    output logic [VW-1:0]     rsp_vc_hi,
    output logic              rsp_xy,
    output logic              rsp_err
);
    localparam int HALF = VPC / 2;

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] port;
        logic [VW-1:0] lo;
        logic [VW-1:0] hi;
        logic          xy;
        logic          err;
    } rsp_t;

    rsp_t          rsp_d, rsp_q;
    logic [PW-1:0] cand_port [2];
    logic [CW-1:0] credit [RADIX];
    logic [CW-1:0] cred_xy, cred_yx;
    logic          tie_bit;

    // candidate ports: index 0 = XY order, index 1 = YX order
    for (genvar g = 0; g < 2; g++) begin : g_order
        frf_port_calc #(
            .K(K), .N(N), .C(C), .DW(DW), .RW(RW), .PW(PW), .YX_ORDER(g == 1)
        ) u_calc (
            .dest    (req_dest),
            .self_id (req_router),
            .port    (cand_port[g])
        );
    end

    for (genvar p = 0; p < RADIX; p++) begin : g_cred
        assign credit[p] = used_credits[p*CW +: CW];
    end

    frf_lfsr #(.SEED(FRF_LFSR_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (req_valid),
        .rnd_bit (tie_bit)
    );

    assign cred_xy = (int'(cand_port[0]) < RADIX) ? credit[cand_port[0]] : '0;
    assign cred_yx = (int'(cand_port[1]) < RADIX) ? credit[cand_port[1]] : '0;

    always_comb begin
        int   base, off;
        logic inject, xy, at_dest, class_ok;
        logic [PW-1:0] sel;
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        inject   = int'(req_in_port) < C;
        base     = int'(req_class) * VPC;
        off      = int'(req_vc) - base;
        class_ok = (off >= 0) && (off < VPC);
        at_dest  = (int'(req_dest) / C) == int'(req_router);
        if (inject) begin
            if (cred_xy < cred_yx)      xy = 1'b1;
            else if (cred_xy > cred_yx) xy = 1'b0;
            else                        xy = tie_bit;
        end else begin
            xy = (off < HALF);
        end
        sel = xy ? cand_port[0] : cand_port[1];
        if (req_valid) begin
            rsp_d.port = sel;
            rsp_d.xy   = xy;
            if (at_dest) begin
                rsp_d.lo = VW'(base);
                rsp_d.hi = VW'(base + VPC - 1);
            end else if (xy) begin
                rsp_d.lo = VW'(base);
                rsp_d.hi = VW'(base + HALF - 1);
            end else begin
                rsp_d.lo = VW'(base + HALF);
                rsp_d.hi = VW'(base + VPC - 1);
            end
            rsp_d.err = (int'(req_in_port) >= RADIX) || (int'(sel) >= RADIX) ||
                        (!inject && !class_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_port  = rsp_q.port;
    assign rsp_vc_lo = rsp_q.lo;
    assign rsp_vc_hi = rsp_q.hi;
    assign rsp_xy    = rsp_q.xy;
    assign rsp_err   = rsp_q.err;
endmodule

// File: rtl/frf_route_chk.sv
module frf_route_chk #(
    parameter int C = 4,
    parameter int VPC = 4,
    parameter int RADIX = 10,
    parameter int PW = 4,
    parameter int VW = 3,
    parameter int CLW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [PW-1:0]  req_in_port,
    input logic [CLW-1:0] req_class,
    input logic [VW-1:0]  req_vc,
    input logic           rsp_valid,
    input logic [PW-1:0]  rsp_port,
    input logic [VW-1:0]  rsp_vc_lo,
    input logic [VW-1:0]  rsp_vc_hi,
    input logic           rsp_xy,
    input logic           rsp_err
);
    localparam int HALF = VPC / 2;

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R7
    vc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_vc_lo <= rsp_vc_hi);
    // R1
    eject_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && int'(rsp_port) < C) |->
        (int'(rsp_vc_hi) - int'(rsp_vc_lo) == VPC - 1));
    // R7
    transit_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && int'(rsp_port) >= C) |->
        ((int'(rsp_vc_hi) - int'(rsp_vc_lo) == HALF - 1) &&
         (rsp_xy == ((int'(rsp_vc_lo) % VPC) < HALF))));
    // R9
    port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> int'(rsp_port) < RADIX);
    // R6
    hop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_in_port) >= C && int'(req_in_port) < RADIX &&
         (int'(req_vc) / VPC == int'(req_class))) |=>
        (rsp_xy == ((int'($past(req_vc)) % VPC) < HALF)));
endmodule

bind frf_route_unit frf_route_chk #(
    .C(C), .VPC(VPC), .RADIX(RADIX), .PW(PW), .VW(VW), .CLW(CLW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in_port(req_in_port),
    .req_class(req_class), .req_vc(req_vc), .rsp_valid(rsp_valid),
    .rsp_port(rsp_port), .rsp_vc_lo(rsp_vc_lo), .rsp_vc_hi(rsp_vc_hi),
    .rsp_xy(rsp_xy), .rsp_err(rsp_err)
);

// File: tb/frf_route_unit_bench.sv
module frf_route_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int K = 4, N = 2, C = 4, VPC = 4, CW = 4;
    localparam int RADIX = C + (K - 1) * N;
    localparam int HALF = VPC / 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [5:0] req_dest = '0;
    logic [3:0] req_router = '0, req_in_port = '0;
    logic [0:0] req_class = '0;
    logic [2:0] req_vc = '0;
    logic [RADIX*CW-1:0] used_credits = '0;
    logic rsp_valid, rsp_xy, rsp_err;
    logic [3:0] rsp_port;
    logic [2:0] rsp_vc_lo, rsp_vc_hi;

    int nchk = 0, nfail = 0;
    int cred [RADIX];
    logic [15:0] lf = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    frf_route_unit u_frf_route_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_router(req_router), .req_in_port(req_in_port), .req_class(req_class),
        .req_vc(req_vc), .used_credits(used_credits), .rsp_valid(rsp_valid),
        .rsp_port(rsp_port), .rsp_vc_lo(rsp_vc_lo), .rsp_vc_hi(rsp_vc_hi),
        .rsp_xy(rsp_xy), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 R3: expected port for a given order
    function automatic int exp_port(input int dst, input int rt, input bit xy);
        int dr, dx, sx, dy, sy, p0, p1;
        dr = dst / C;
        if (dr == rt) return dst % C;
        dx = dr % K; sx = rt % K; dy = dr / K; sy = rt / K;
        p0 = (dx > sx) ? (C - 1 + dx) : (C + dx);
        p1 = (dy > sy) ? (C + (K - 1) - 1 + dy) : (C + (K - 1) + dy);
        if (xy) return (dx != sx) ? p0 : p1;
        return (dy != sy) ? p1 : p0;
    endfunction

    task automatic set_credits(input int seed, input bit flat);
        for (int p = 0; p < RADIX; p++) begin
            cred[p] = flat ? 7 : ((p * 5 + seed * 3) % 16);
            used_credits[p*CW +: CW] = CW'(cred[p]);
        end
    endtask

    task automatic route(input int dst, input int rt, input int inp, input int cls,
                         input int vc, input bit exp_err);
        bit inject, xy, tie, eject;
        int pxy, pyx, base, lo, hi;
        req_valid = 1'b1; req_dest = 6'(dst); req_router = 4'(rt);
        req_in_port = 4'(inp); req_class = 1'(cls); req_vc = 3'(vc);
        inject = inp < C;
        pxy = exp_port(dst, rt, 1'b1);
        pyx = exp_port(dst, rt, 1'b0);
        tie = 1'b0;
        if (inject) begin
            if (cred[pxy] < cred[pyx]) xy = 1'b1;
            else if (cred[pxy] > cred[pyx]) xy = 1'b0;
            else begin xy = lf[0]; tie = 1'b1; end
        end else begin
            xy = (vc - cls * VPC) < HALF;
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        eject = (dst / C) == rt;
        base = cls * VPC;
        if (eject) begin lo = base; hi = base + VPC - 1; end
        else if (xy) begin lo = base; hi = base + HALF - 1; end
        else begin lo = base + HALF; hi = base + VPC - 1; end
        @(posedge clk);
        @(negedge clk);
        check("R8 rsp_valid", int'(rsp_valid), 1);
        check("R9 rsp_err", int'(rsp_err), int'(exp_err));
        if (!exp_err) begin
            if (inject) check(tie ? "R5 tie order" : "R4 credit order", int'(rsp_xy), int'(xy));
            else        check("R6 inferred order", int'(rsp_xy), int'(xy));
            check(eject ? "R1 eject port" : "R2/R3 port", int'(rsp_port), xy ? pxy : pyx);
            check(eject ? "R1 vc lo" : "R7 vc lo", int'(rsp_vc_lo), lo);
            check(eject ? "R1 vc hi" : "R7 vc hi", int'(rsp_vc_hi), hi);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        set_credits(0, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 reset rsp_valid", int'(rsp_valid), 0);
        check("R8 reset rsp_err", int'(rsp_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 R2 R3 R1: transit sweep, both VC halves
        for (int rt = 0; rt < 16; rt++)
            for (int dst = 0; dst < 64; dst++)
                for (int h = 0; h < 2; h++)
                    route(dst, rt, C + (dst % (RADIX - C)), (rt + dst) % 2,
                          ((rt + dst) % 2) * VPC + h * HALF + (dst % 2), 1'b0);
        // R4 R5: injection sweeps; VC deliberately outside class (ignored, R9)
        for (int s = 0; s < 3; s++) begin
            set_credits(s, s == 2);
            for (int rt = 0; rt < 16; rt++)
                for (int dst = 0; dst < 64; dst++)
                    route(dst, rt, dst % C, rt % 2, 7 - (rt % 2) * 4, 1'b0);
        end
        // R9: bad input port and VC outside class on a transit hop
        route(20, 3, 12, 0, 1, 1'b1);
        route(20, 3, 15, 1, 5, 1'b1);
        route(40, 9, 6, 0, 6, 1'b1);
        route(40, 9, 7, 1, 2, 1'b1);
        // R8: idle cycle drops valid
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 idle rsp_valid", int'(rsp_valid), 0);
        // R5: tie after error requests still tracks the LFSR
        set_credits(0, 1'b1);
        route(5, 0, 2, 0, 0, 1'b0);
        route(33, 7, 1, 1, 4, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule